// File: doc/BRIEF.md
# Multi-Mode Multiply-Accumulate Engine

This block multiplies two operands over several clock cycles and either places the product in a 64-bit accumulator or adds it there. It runs in one of four modes. The first is a 16x16 multiply. The second is a 16x16 multiply-accumulate. The third is a 32x32 multiply that keeps the full 64-bit product. The fourth is a 32x32 multiply-accumulate. A single signed/unsigned select sets how both operands are read. The accumulator is read as a high word and a low word. Software-side logic can write either word, or clear the whole accumulator, while the engine is idle.

Inside, a single 16x16 multiplier array is reused once for each pair of 16-bit operand chunks. In the 32-bit modes, an upper operand half that adds no information is skipped. An unsigned upper half adds no information when it is all zeros. A signed upper half adds no information when it is all copies of bit 15. Skipping it shortens the run. Latency therefore depends on the mode and on the operand values, but it always stays inside a fixed bound for each mode. A caller pulses `start` with the operands. It then waits for `done` and reads the accumulator.

Top module: `mulacc_engine`

## Requirements
- R1: With `op_sel`=2'b00 (16-bit multiply), the accumulator becomes the product of `opnd_a[15:0]` and `opnd_b[15:0]`. Each operand is sign-extended when `sign_sel`=1 and zero-extended otherwise. The product is extended to 64 bits the same way. Bits 31:16 of the operands have no effect.
- R2: With `op_sel`=2'b01 (16-bit multiply-accumulate), the R1 product is added to the accumulator modulo 2^64.
- R3: With `op_sel`=2'b10 (32-bit multiply), the accumulator becomes the full 64-bit product of the two 32-bit operands. The operands are signed when `sign_sel`=1.
- R4: With `op_sel`=2'b11 (32-bit multiply-accumulate), the R3 product is added to the accumulator modulo 2^64.
- R5: Latency is the number of cycles `busy` stays high. It is 1 for the 16-bit multiply and 2 for the 16-bit multiply-accumulate. For a 32-bit mode, count each operand as 1 when its upper half is redundant and as 2 otherwise. The latency is then the larger of 2 and the product of the two counts, which always lies between 2 and 4.
- R6: After reset, the accumulator reads 0 and `busy` and `done` are low. `busy` rises in the cycle after an accepted `start`. `done` is high for exactly one cycle, and that cycle is the first one in which `busy` is low again.
- R7: A `start` while `busy` is high is ignored. It produces no extra `done` and does not change the running result.
- R8: `acc_clr`, `acc_wr_hi` and `acc_wr_lo` are ignored while `busy` is high.
- R9: While idle, `acc_wr_hi` loads `acc_wr_data` into bits 63:32 and `acc_wr_lo` loads it into bits 31:0. Each word is written independently. `acc_clr` takes priority over both and zeroes all 64 bits. A write in the same cycle as an accepted `start` takes effect, and a multiply-accumulate started in that cycle adds onto the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation (accepted only while idle) |
| op_sel | input | 2 | Mode: 00 mul16, 01 mac16, 10 mul32, 11 mac32 |
| sign_sel | input | 1 | 1 = signed operands, 0 = unsigned |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| acc_clr | input | 1 | Zero the accumulator (idle only) |
| acc_wr_hi | input | 1 | Write high accumulator word (idle only) |
| acc_wr_lo | input | 1 | Write low accumulator word (idle only) |
| acc_wr_data | input | 32 | Data for accumulator word writes |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| acc_hi | output | 32 | Accumulator bits 63:32 |
| acc_lo | output | 32 | Accumulator bits 31:0 |

## Verification
Accumulator access and the multiply datapath meet in two places. The first is when an accumulator write arrives in the same cycle as an accepted `start`. The bench provokes this by writing both words while launching a 16-bit multiply-accumulate, and it judges the result by expecting the written value plus the product. The second is when a clear, a word write and a second `start` arrive during a 4-cycle 32-bit run. There the scoreboard expects the untouched product, a single `done` and the unchanged latency.

// File: rtl/mulacc_pkg.sv
package mulacc_pkg;
   typedef enum logic [1:0] {
      OP_MUL16 = 2'b00,
      OP_MAC16 = 2'b01,
      OP_MUL32 = 2'b10,
      OP_MAC32 = 2'b11
   } mulacc_op_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_FIN  = 2'd2
   } mulacc_state_e;
endpackage

// File: rtl/mulacc_span.sv
// Decides whether an operand's upper chunk carries information.
module mulacc_span #(
   parameter int OPND_W  = 32,
   parameter int CHUNK_W = 16
) (
   input  logic [OPND_W-1:0] opnd,
   input  logic              sgn,
   input  logic              wide,
   output logic              need_upper
);
   localparam int UP_W = OPND_W - CHUNK_W;

   logic [UP_W-1:0] fill;
   logic [UP_W-1:0] diff;

   genvar gi;
   generate
      for (gi = 0; gi < UP_W; gi++) begin : g_bit
         assign fill[gi] = sgn & opnd[CHUNK_W-1];
         assign diff[gi] = opnd[CHUNK_W+gi] ^ fill[gi];
      end
   endgenerate

   assign need_upper = wide & (|diff);
endmodule

// File: rtl/mulacc_chunk_mul.sv
// One chunk-pair multiply; each chunk is extended by one bit, signed or zero.
module mulacc_chunk_mul #(
   parameter int CHUNK_W = 16,
   localparam int PP_W   = 2 * CHUNK_W + 2
) (
   input  logic [CHUNK_W-1:0] a_chunk,
   input  logic               a_sext,
   input  logic [CHUNK_W-1:0] b_chunk,
   input  logic               b_sext,
   output logic [PP_W-1:0]    pp
);
   logic signed [CHUNK_W:0] a_x;
   logic signed [CHUNK_W:0] b_x;
   logic signed [PP_W-1:0]  prod;

   assign a_x  = {a_sext & a_chunk[CHUNK_W-1], a_chunk};
   assign b_x  = {b_sext & b_chunk[CHUNK_W-1], b_chunk};
   assign prod = a_x * b_x;
   assign pp   = prod;
endmodule

// File: rtl/mulacc_engine.sv
module mulacc_engine
   import mulacc_pkg::*;
#(
   parameter int CHUNK_W = 16,
   parameter int OPND_W  = 32,
   parameter int ACC_W   = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [1:0]        op_sel,
   input  logic              sign_sel,
   input  logic [OPND_W-1:0] opnd_a,
   input  logic [OPND_W-1:0] opnd_b,
   input  logic              acc_clr,
   input  logic              acc_wr_hi,
   input  logic              acc_wr_lo,
   input  logic [OPND_W-1:0] acc_wr_data,
   output logic              busy,
   output logic              done,
   output logic [OPND_W-1:0] acc_hi,
   output logic [OPND_W-1:0] acc_lo
);
   localparam int PP_W = 2 * CHUNK_W + 2;
   localparam int HALF = ACC_W / 2;

   generate
      if (OPND_W != 2 * CHUNK_W) begin : g_bad_chunk
         $error("mulacc_engine: OPND_W must be two chunks");
      end
      if (ACC_W != 2 * OPND_W) begin : g_bad_acc
         $error("mulacc_engine: ACC_W must be twice OPND_W");
      end
   endgenerate

   mulacc_state_e     state_q;
   logic [OPND_W-1:0] a_q, b_q;
   logic              sgn_q, accum_q, wide_q;
   logic              a_two_q, b_two_q;
   logic [1:0]        idx_q;
   logic [ACC_W-1:0]  work_q, acc_q;

   logic              wide_in, a_two_in, b_two_in;
   logic              sel_a, sel_b, a_sext, b_sext, last, pad;
   logic [1:0]        last_idx;
   logic [CHUNK_W-1:0] a_chunk, b_chunk;
   logic [PP_W-1:0]   pp;
   logic [ACC_W-1:0]  pp_ext, shifted, next_work, base;
   int unsigned       sh;

   assign wide_in = op_sel[1];

   mulacc_span #(.OPND_W(OPND_W), .CHUNK_W(CHUNK_W)) i_span_a (
      .opnd(opnd_a), .sgn(sign_sel), .wide(wide_in), .need_upper(a_two_in));
   mulacc_span #(.OPND_W(OPND_W), .CHUNK_W(CHUNK_W)) i_span_b (
      .opnd(opnd_b), .sgn(sign_sel), .wide(wide_in), .need_upper(b_two_in));

   // chunk-pair sequence: b chunk varies fastest
   assign sel_a    = a_two_q & (b_two_q ? idx_q[1] : idx_q[0]);
   assign sel_b    = b_two_q & idx_q[0];
   assign last_idx = {a_two_q & b_two_q, a_two_q | b_two_q};
   assign last     = (idx_q == last_idx);
   assign pad      = (accum_q & ~wide_q) | (wide_q & ~a_two_q & ~b_two_q);

   assign a_chunk = sel_a ? a_q[OPND_W-1:CHUNK_W] : a_q[CHUNK_W-1:0];
   assign b_chunk = sel_b ? b_q[OPND_W-1:CHUNK_W] : b_q[CHUNK_W-1:0];
   assign a_sext  = sgn_q & (sel_a | ~a_two_q);
   assign b_sext  = sgn_q & (sel_b | ~b_two_q);

   mulacc_chunk_mul #(.CHUNK_W(CHUNK_W)) i_mul (
      .a_chunk(a_chunk), .a_sext(a_sext),
      .b_chunk(b_chunk), .b_sext(b_sext), .pp(pp));

   always_comb begin
      sh        = (32'(sel_a) + 32'(sel_b)) * CHUNK_W;
      pp_ext    = {{(ACC_W-PP_W){pp[PP_W-1]}}, pp};
      shifted   = pp_ext << sh;
      next_work = work_q + shifted;
      base      = accum_q ? acc_q : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         a_q     <= '0;
         b_q     <= '0;
         sgn_q   <= 1'b0;
         accum_q <= 1'b0;
         wide_q  <= 1'b0;
         a_two_q <= 1'b0;
         b_two_q <= 1'b0;
         idx_q   <= '0;
         work_q  <= '0;
         acc_q   <= '0;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (acc_clr) begin
                  acc_q <= '0;
               end else begin
                  if (acc_wr_hi) acc_q[ACC_W-1:HALF] <= acc_wr_data;
                  if (acc_wr_lo) acc_q[HALF-1:0]     <= acc_wr_data;
               end
               if (start) begin
                  a_q     <= opnd_a;
                  b_q     <= opnd_b;
                  sgn_q   <= sign_sel;
                  accum_q <= op_sel[0];
                  wide_q  <= wide_in;
                  a_two_q <= a_two_in;
                  b_two_q <= b_two_in;
                  idx_q   <= '0;
                  work_q  <= '0;
                  state_q <= ST_RUN;
               end
            end
            ST_RUN: begin
               if (!last) begin
                  work_q <= next_work;
                  idx_q  <= idx_q + 2'd1;
               end else if (pad) begin
                  work_q  <= next_work;
                  state_q <= ST_FIN;
               end else begin
                  acc_q   <= base + next_work;
                  done    <= 1'b1;
                  state_q <= ST_IDLE;
               end
            end
            ST_FIN: begin
               acc_q   <= base + work_q;
               done    <= 1'b1;
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy   = (state_q != ST_IDLE);
   assign acc_hi = acc_q[ACC_W-1:HALF];
   assign acc_lo = acc_q[HALF-1:0];
endmodule

// File: rtl/mulacc_engine_chk.sv
module mulacc_engine_chk #(
   parameter int OPND_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              busy,
   input logic              done,
   input logic              acc_clr,
   input logic              acc_wr_hi,
   input logic              acc_wr_lo,
   input logic [OPND_W-1:0] acc_hi,
   input logic [OPND_W-1:0] acc_lo
);
   logic [2:0] run_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                run_cnt <= '0;
      else if (start && !busy)   run_cnt <= '0;
      else if (busy && run_cnt != 3'd7) run_cnt <= run_cnt + 3'd1;
   end

   assert_busy_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);
   assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_done_ends_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));
   assert_latency_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (run_cnt >= 3'd1 && run_cnt <= 3'd4));
   assert_busy_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (run_cnt < 3'd4));
   assert_acc_held_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable({acc_hi, acc_lo}) || done));
   assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && acc_clr) |=> ({acc_hi, acc_lo} == '0));
   assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !acc_clr && !acc_wr_hi && !acc_wr_lo) |=> $stable({acc_hi, acc_lo}));
endmodule

bind mulacc_engine mulacc_engine_chk #(.OPND_W(OPND_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
   .acc_clr(acc_clr), .acc_wr_hi(acc_wr_hi), .acc_wr_lo(acc_wr_lo),
   .acc_hi(acc_hi), .acc_lo(acc_lo));

// File: tb/test_mulacc_engine.sv
`timescale 1ns/1ps
module test_mulacc_engine;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [1:0]  op_sel = 2'b00;
   logic        sign_sel = 1'b0;
   logic [31:0] opnd_a = '0, opnd_b = '0;
   logic        acc_clr = 1'b0, acc_wr_hi = 1'b0, acc_wr_lo = 1'b0;
   logic [31:0] acc_wr_data = '0;
   logic        busy, done;
   logic [31:0] acc_hi, acc_lo;

   int total = 0;
   int bad = 0;
   int lat_run = 0;
   logic [63:0] model_acc = '0;

   typedef struct {
      logic [63:0] val;
      int          lat;
      int          lo_b;
      int          hi_b;
      string       tag;
   } exp_t;
   exp_t sb_q[$];

   always #2.5 clk = ~clk;

   mulacc_engine i_mulacc_engine (
      .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel),
      .sign_sel(sign_sel), .opnd_a(opnd_a), .opnd_b(opnd_b),
      .acc_clr(acc_clr), .acc_wr_hi(acc_wr_hi), .acc_wr_lo(acc_wr_lo),
      .acc_wr_data(acc_wr_data), .busy(busy), .done(done),
      .acc_hi(acc_hi), .acc_lo(acc_lo));

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [63:0] ext(input logic [31:0] v, input bit sg, input bit wide);
      if (wide) return sg ? {{32{v[31]}}, v} : {32'b0, v};
      return sg ? {{48{v[15]}}, v[15:0]} : {48'b0, v[15:0]};
   endfunction

   function automatic int cnt_of(input logic [31:0] v, input bit sg);
      logic [15:0] fill;
      fill = sg ? {16{v[15]}} : 16'h0;
      return (v[31:16] == fill) ? 1 : 2;
   endfunction

   function automatic int exp_lat(input logic [1:0] op, input bit sg, input logic [31:0] a, input logic [31:0] b);
      int n;
      if (!op[1]) return op[0] ? 2 : 1;
      n = cnt_of(a, sg) * cnt_of(b, sg);
      return (n < 2) ? 2 : n;
   endfunction

   function automatic exp_t make_exp(input logic [1:0] op, input bit sg, input logic [31:0] a,
                                     input logic [31:0] b, input string tag);
      exp_t e;
      logic [63:0] prod;
      prod = ext(a, sg, op[1]) * ext(b, sg, op[1]);
      model_acc = op[0] ? (model_acc + prod) : prod;
      e.val  = model_acc;
      e.lat  = exp_lat(op, sg, a, b);
      e.lo_b = (op == 2'b00) ? 1 : 2;
      e.hi_b = (op == 2'b00) ? 2 : ((op == 2'b01) ? 3 : 4);
      e.tag  = tag;
      return e;
   endfunction

   task automatic wait_empty();
      while (sb_q.size() != 0) @(negedge clk);
      @(negedge clk);
   endtask

   // driver: optional same-cycle word writes with the start
   task automatic run_op(input logic [1:0] op, input bit sg, input logic [31:0] a,
                         input logic [31:0] b, input string tag,
                         input bit with_wr = 0, input logic [31:0] wd = '0);
      if (with_wr) model_acc = {wd, wd};
      sb_q.push_back(make_exp(op, sg, a, b, tag));
      start = 1'b1; op_sel = op; sign_sel = sg; opnd_a = a; opnd_b = b;
      acc_wr_hi = with_wr; acc_wr_lo = with_wr; acc_wr_data = wd;
      @(negedge clk);
      start = 1'b0; acc_wr_hi = 1'b0; acc_wr_lo = 1'b0;
      chk(busy === 1'b1, "R6 busy after start", {63'b0, busy}, 64'd1);
      wait_empty();
   endtask

   task automatic acc_access(input bit clr, input bit hi, input bit lo, input logic [31:0] d, input string tag);
      acc_clr = clr; acc_wr_hi = hi; acc_wr_lo = lo; acc_wr_data = d;
      if (clr) model_acc = '0;
      else begin
         if (hi) model_acc[63:32] = d;
         if (lo) model_acc[31:0]  = d;
      end
      @(negedge clk);
      acc_clr = 1'b0; acc_wr_hi = 1'b0; acc_wr_lo = 1'b0;
      chk({acc_hi, acc_lo} === model_acc, tag, {acc_hi, acc_lo}, model_acc);
   endtask

   // monitor: pops the scoreboard when a result appears
   always @(negedge clk) begin
      if (rst_n) begin
         if (busy) lat_run++;
         if (done) begin
            chk(!busy, "R6 done with busy low", {63'b0, busy}, 64'd0);
            if (sb_q.size() == 0) begin
               chk(1'b0, "R7 unexpected done", 64'd1, 64'd0);
            end else begin
               exp_t e;
               e = sb_q.pop_front();
               chk({acc_hi, acc_lo} === e.val, e.tag, {acc_hi, acc_lo}, e.val);
               chk(lat_run == e.lat, {e.tag, " R5 latency"}, 64'(lat_run), 64'(e.lat));
               chk(lat_run >= e.lo_b && lat_run <= e.hi_b, {e.tag, " R5 bound"},
                   64'(lat_run), 64'(e.hi_b));
            end
            lat_run = 0;
         end
      end
   end

   task automatic finish_up();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog R6 actual=hung expected=finish");
      finish_up();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk({acc_hi, acc_lo} === 64'd0, "R6 reset acc", {acc_hi, acc_lo}, 64'd0);
      chk(busy === 1'b0 && done === 1'b0, "R6 reset flags", {62'b0, busy, done}, 64'd0);

      // R1: 16-bit multiply, upper bits garbage
      run_op(2'b00, 1'b0, 32'hDEAD_FFFF, 32'hBEEF_FFFF, "R1 mul16 unsigned");
      run_op(2'b00, 1'b1, 32'h1234_8000, 32'h0000_7FFF, "R1 mul16 signed");
      run_op(2'b00, 1'b1, 32'hFFFF_FFFD, 32'hAAAA_FFF9, "R1 mul16 neg*neg");
      // R2: 16-bit accumulate
      run_op(2'b01, 1'b1, 32'h0000_FFFF, 32'h0000_0005, "R2 mac16 signed");
      run_op(2'b01, 1'b0, 32'h0000_FFFF, 32'h0000_FFFF, "R2 mac16 unsigned");
      // R3: 32-bit multiply with skips of varied extent
      run_op(2'b10, 1'b0, 32'h1234_5678, 32'h9ABC_DEF0, "R3 mul32 full");
      run_op(2'b10, 1'b0, 32'h0000_1234, 32'h0000_5678, "R3 mul32 short");
      run_op(2'b10, 1'b1, 32'hFFFF_8000, 32'h7FFF_FFFF, "R3 mul32 signed 1x2");
      run_op(2'b10, 1'b1, 32'h8000_0000, 32'hFFFF_FFFF, "R3 mul32 signed 2x1");
      run_op(2'b10, 1'b1, 32'h8000_0000, 32'h8000_0000, "R3 mul32 min*min");
      // R4: 32-bit accumulate with wrap
      acc_access(1'b0, 1'b1, 1'b1, 32'hFFFF_FFFF, "R9 load both words");
      run_op(2'b11, 1'b0, 32'hFFFF_FFFF, 32'h0000_0002, "R4 mac32 wrap");
      run_op(2'b11, 1'b1, 32'hFFFF_FFF0, 32'h0001_0000, "R4 mac32 signed");

      // R7 and R8: disturbances during a 4-cycle run
      sb_q.push_back(make_exp(2'b10, 1'b0, 32'h8765_4321, 32'hFEDC_BA98, "R7 R8 busy disturb"));
      start = 1'b1; op_sel = 2'b10; sign_sel = 1'b0;
      opnd_a = 32'h8765_4321; opnd_b = 32'hFEDC_BA98;
      @(negedge clk);
      opnd_a = 32'h1111_1111; opnd_b = 32'h2222_2222; op_sel = 2'b00; acc_clr = 1'b1;
      @(negedge clk);
      start = 1'b0; acc_clr = 1'b0; acc_wr_hi = 1'b1; acc_wr_lo = 1'b1; acc_wr_data = 32'h5555_5555;
      @(negedge clk);
      acc_wr_hi = 1'b0; acc_wr_lo = 1'b0;
      wait_empty();
      repeat (6) @(negedge clk);
      chk(sb_q.size() == 0 && !busy, "R7 no second run", {63'b0, busy}, 64'd0);

      // R9: idle word access and same-cycle start
      acc_access(1'b0, 1'b1, 1'b0, 32'hA5A5_0001, "R9 write high only");
      acc_access(1'b0, 1'b0, 1'b1, 32'h0F0F_0002, "R9 write low only");
      acc_access(1'b1, 1'b1, 1'b1, 32'h1234_5678, "R9 clear beats write");
      run_op(2'b01, 1'b0, 32'h0000_0100, 32'h0000_0003, "R9 write with start", 1'b1, 32'h0000_0010);

      finish_up();
   end
endmodule